// File: doc/BRIEF.md
# Packed Short-Vector Step Executor

This block runs the packed short-vector mode of a vector display engine. Each 16-bit display word holds two 8-bit commands. The upper byte runs first and the lower byte runs second. A command with bit 7 set is an *increment*. It moves the beam position by small signed steps, multiplied by the current scale, and can ask for a line to be drawn. A command with bit 7 clear is a *control* command. It bumps or trims the coarse and fine parts of the position, pops the return stack, or leaves the mode.

The surrounding engine pulses `start_i` with the word and the current position, scale code and return-stack depth. The block sets its outputs at that clock edge. If a second byte has to run, the block is busy for one more cycle and shows the second byte's results at the next edge. The flags `step_o` and `done_o` mark each executed byte and the last one. When the word is the one that enters the mode, `entry_i` is set, and only its low byte runs. Line rasterisation belongs to a downstream unit, which is fed through the draw request outputs.

Top module: `incvec_exec`

## Requirements
- R1: After reset every output is 0 and `busy_o` is 0.
- R2: In an increment byte (bit 7 = 1), X moves by the magnitude in bits 4:3 and Y by the magnitude in bits 1:0. Each magnitude is shifted left by the 2-bit scale code (codes 0..3 give factors 1, 2, 4, 8). The step is subtracted when the sign bit is set (bit 5 for X, bit 2 for Y) and added otherwise. Both coordinates wrap modulo 2^11.
- R3: `draw_o` is set for a byte only when that byte is an increment with bit 6 set. It then carries the start point (`draw_x0_o`, `draw_y0_o`) and the end point (`draw_x1_o`, `draw_y1_o`), and the end point equals the new position.
- R4: In a control byte (bit 7 = 0), bit 4 adds 32 to X and bit 3 clears X[4:0]. Bit 1 adds 32 to Y and bit 0 clears Y[4:0]. When a byte requests both the add and the clear, the add is applied first. Results wrap modulo 2^11.
- R5: A control byte with bit 5 set and a stack depth above 0 raises `pop_o`. A pop in the high byte lowers the depth that the low byte sees by one.
- R6: A control byte with bit 5 set and a depth of 0 raises `illegal_o` and not `pop_o`, and it ends the word (`done_o`).
- R7: A control byte with bit 6 set raises `exit_o` and ends the word, so the low byte is not executed.
- R8: When `entry_i` = 0, the high byte's results appear at the edge that samples `start_i`. If that byte neither exits nor is illegal, the low byte's results appear one edge later with `done_o`, computed from the high byte's position and depth. `busy_o` is 1 only in between.
- R9: When `entry_i` = 1, only bits 7:0 of the word execute, and `done_o` is set with that single step.
- R10: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin executing `word_i` |
| entry_i | input | 1 | Word is the mode-entry word: run its low byte only |
| word_i | input | 16 | Two packed commands, high byte first |
| x_i | input | 11 | Current X position |
| y_i | input | 11 | Current Y position |
| scale_i | input | 2 | Scale code, factor 2^code |
| depth_i | input | 4 | Current return-stack depth |
| busy_o | output | 1 | Low byte pending |
| step_o | output | 1 | A byte was executed at the last edge |
| done_o | output | 1 | That byte finished the word |
| x_o | output | 11 | New X position |
| y_o | output | 11 | New Y position |
| draw_o | output | 1 | Line draw request |
| draw_x0_o | output | 11 | Draw start X |
| draw_y0_o | output | 11 | Draw start Y |
| draw_x1_o | output | 11 | Draw end X |
| draw_y1_o | output | 11 | Draw end Y |
| exit_o | output | 1 | Leave the packed mode |
| pop_o | output | 1 | Pop the return stack into the program counter |
| illegal_o | output | 1 | Return requested on an empty stack |

## Verification
The hardest case to reach is a low byte whose outcome depends on what the high byte left behind. The clearest example is a return in both bytes with a depth of one: the first pops, and the second must then find the stack empty and flag an illegal return. The bench builds such words on purpose, and also high-byte exits and illegal returns, then watches for one cycle after `done_o` to confirm that no second step appears. A start pulse held through the busy cycle with a different word checks that the pending low byte is not disturbed.

// File: rtl/incvec_pkg.sv
package incvec_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOW  = 1'b1
    } exec_st_e;

    localparam int KIND_BIT  = 7;
    localparam int BEAM_BIT  = 6;
    localparam int LEAVE_BIT = 6;
    localparam int RET_BIT   = 5;
endpackage

// File: rtl/incvec_axis.sv
module incvec_axis #(
    parameter int CW = 11,
    parameter int FW = 5
) (
    input  logic [CW-1:0] coord_i,
    input  logic          is_inc_i,
    input  logic          neg_i,
    input  logic [1:0]    mag_i,
    input  logic [1:0]    scale_i,
    input  logic          bump_i,
    input  logic          trim_i,
    output logic [CW-1:0] coord_o
);
    localparam logic [CW-1:0] COARSE_ONE = CW'(1) << FW;
    localparam logic [CW-1:0] FINE_MASK  = COARSE_ONE - CW'(1);

    logic [CW-1:0] step_w;
    logic [CW-1:0] ctrl_w;

    always_comb begin
        step_w = CW'(mag_i) << scale_i;
        ctrl_w = bump_i ? coord_i + COARSE_ONE : coord_i;
        if (trim_i) begin
            ctrl_w = ctrl_w & ~FINE_MASK;
        end
        if (is_inc_i) begin
            coord_o = neg_i ? coord_i - step_w : coord_i + step_w;
        end else begin
            coord_o = ctrl_w;
        end
    end
endmodule

// File: rtl/incvec_byte.sv
module incvec_byte #(
    parameter int CW = 11,
    parameter int FW = 5,
    parameter int DW = 4
) (
    input  logic [7:0]    cmd_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic [1:0]    scale_i,
    input  logic [DW-1:0] depth_i,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          draw_o,
    output logic          exit_o,
    output logic          pop_o,
    output logic          illegal_o
);
    import incvec_pkg::*;

    logic          is_inc;
    logic          ret_req;
    logic [CW-1:0] cin  [2];
    logic [CW-1:0] cout [2];

    assign is_inc    = cmd_i[KIND_BIT];
    assign draw_o    = is_inc & cmd_i[BEAM_BIT];
    assign exit_o    = ~is_inc & cmd_i[LEAVE_BIT];
    assign ret_req   = ~is_inc & cmd_i[RET_BIT];
    assign pop_o     = ret_req & (depth_i != '0);
    assign illegal_o = ret_req & (depth_i == '0);

    assign cin[0] = x_i;
    assign cin[1] = y_i;
    assign x_o    = cout[0];
    assign y_o    = cout[1];

    // axis 0 uses cmd bits 5:3, axis 1 uses cmd bits 2:0
    for (genvar a = 0; a < 2; a++) begin : g_axis
        localparam int B = 5 - 3 * a;
        incvec_axis #(.CW(CW), .FW(FW)) axis_i (
            .coord_i (cin[a]),
            .is_inc_i(is_inc),
            .neg_i   (cmd_i[B]),
            .mag_i   (cmd_i[B-1:B-2]),
            .scale_i (scale_i),
            .bump_i  (cmd_i[B-1]),
            .trim_i  (cmd_i[B-2]),
            .coord_o (cout[a])
        );
    end
endmodule

// File: rtl/incvec_exec.sv
module incvec_exec #(
    parameter int CW = 11,
    parameter int FW = 5,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          entry_i,
    input  logic [15:0]   word_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic [1:0]    scale_i,
    input  logic [DW-1:0] depth_i,
    output logic          busy_o,
    output logic          step_o,
    output logic          done_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          draw_o,
    output logic [CW-1:0] draw_x0_o,
    output logic [CW-1:0] draw_y0_o,
    output logic [CW-1:0] draw_x1_o,
    output logic [CW-1:0] draw_y1_o,
    output logic          exit_o,
    output logic          pop_o,
    output logic          illegal_o
);
    import incvec_pkg::*;

    typedef struct packed {
        exec_st_e      st;
        logic [7:0]    lo;
        logic [DW-1:0] depth;
        logic [1:0]    scale;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic [CW-1:0] x0;
        logic [CW-1:0] y0;
        logic          step;
        logic          done;
        logic          draw;
        logic          leave;
        logic          pop;
        logic          bad;
    } exec_s;

    exec_s s_d, s_q;

    logic [7:0]    cmd;
    logic [CW-1:0] cx, cy, nx, ny;
    logic [1:0]    csc;
    logic [DW-1:0] cdep;
    logic          b_draw, b_exit, b_pop, b_bad;
    logic          idle, go, last;

    assign idle = (s_q.st == ST_IDLE);

    always_comb begin
        if (idle) begin
            cmd  = entry_i ? word_i[7:0] : word_i[15:8];
            cx   = x_i;
            cy   = y_i;
            csc  = scale_i;
            cdep = depth_i;
        end else begin
            cmd  = s_q.lo;
            cx   = s_q.x;
            cy   = s_q.y;
            csc  = s_q.scale;
            cdep = s_q.depth;
        end
    end

    incvec_byte #(.CW(CW), .FW(FW), .DW(DW)) byte_i (
        .cmd_i    (cmd),
        .x_i      (cx),
        .y_i      (cy),
        .scale_i  (csc),
        .depth_i  (cdep),
        .x_o      (nx),
        .y_o      (ny),
        .draw_o   (b_draw),
        .exit_o   (b_exit),
        .pop_o    (b_pop),
        .illegal_o(b_bad)
    );

    always_comb begin
        s_d       = s_q;
        s_d.step  = 1'b0;
        s_d.done  = 1'b0;
        s_d.draw  = 1'b0;
        s_d.leave = 1'b0;
        s_d.pop   = 1'b0;
        s_d.bad   = 1'b0;
        go   = (idle && start_i) || !idle;
        last = !idle || entry_i || b_exit || b_bad;
        if (go) begin
            s_d.step  = 1'b1;
            s_d.done  = last;
            s_d.st    = last ? ST_IDLE : ST_LOW;
            s_d.x     = nx;
            s_d.y     = ny;
            s_d.x0    = cx;
            s_d.y0    = cy;
            s_d.draw  = b_draw;
            s_d.leave = b_exit;
            s_d.pop   = b_pop;
            s_d.bad   = b_bad;
            s_d.scale = csc;
            s_d.depth = cdep - DW'(b_pop);
            if (idle) begin
                s_d.lo = word_i[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = !idle;
    assign step_o    = s_q.step;
    assign done_o    = s_q.done;
    assign x_o       = s_q.x;
    assign y_o       = s_q.y;
    assign draw_o    = s_q.draw;
    assign draw_x0_o = s_q.x0;
    assign draw_y0_o = s_q.y0;
    assign draw_x1_o = s_q.x;
    assign draw_y1_o = s_q.y;
    assign exit_o    = s_q.leave;
    assign pop_o     = s_q.pop;
    assign illegal_o = s_q.bad;
endmodule

// File: rtl/incvec_exec_chk.sv
module incvec_exec_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          step_o,
    input logic          done_o,
    input logic          draw_o,
    input logic          exit_o,
    input logic          pop_o,
    input logic          illegal_o,
    input logic [CW-1:0] x_o,
    input logic [CW-1:0] y_o,
    input logic [CW-1:0] draw_x1_o,
    input logic [CW-1:0] draw_y1_o
);
    // R8
    low_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (step_o && done_o && !busy_o));

    // R3
    draw_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draw_o |-> (step_o && draw_x1_o == x_o && draw_y1_o == y_o));

    // R6
    bad_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !pop_o && !busy_o));

    // R7
    leave_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |-> (done_o && !busy_o));

    // R8
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> step_o);

    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_o |-> (!draw_o && !pop_o && !exit_o && !illegal_o));
endmodule

bind incvec_exec incvec_exec_chk #(.CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .step_o   (step_o),
    .done_o   (done_o),
    .draw_o   (draw_o),
    .exit_o   (exit_o),
    .pop_o    (pop_o),
    .illegal_o(illegal_o),
    .x_o      (x_o),
    .y_o      (y_o),
    .draw_x1_o(draw_x1_o),
    .draw_y1_o(draw_y1_o)
);

// File: tb/incvec_exec_tb_top.sv
module incvec_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        entry_i = 1'b0;
    logic [15:0] word_i = '0;
    logic [10:0] x_i = '0;
    logic [10:0] y_i = '0;
    logic [1:0]  scale_i = '0;
    logic [3:0]  depth_i = '0;
    logic        busy_o, step_o, done_o, draw_o, exit_o, pop_o, illegal_o;
    logic [10:0] x_o, y_o, draw_x0_o, draw_y0_o, draw_x1_o, draw_y1_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    incvec_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .entry_i(entry_i),
        .word_i(word_i), .x_i(x_i), .y_i(y_i), .scale_i(scale_i),
        .depth_i(depth_i), .busy_o(busy_o), .step_o(step_o), .done_o(done_o),
        .x_o(x_o), .y_o(y_o), .draw_o(draw_o), .draw_x0_o(draw_x0_o),
        .draw_y0_o(draw_y0_o), .draw_x1_o(draw_x1_o), .draw_y1_o(draw_y1_o),
        .exit_o(exit_o), .pop_o(pop_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result of one byte, from the requirement text.
    typedef struct {
        logic [10:0] x, y;
        logic        draw, leave, pop, bad;
        logic [3:0]  depth;
    } exp_s;

    function automatic logic [10:0] ctl_axis(input logic [10:0] c,
                                             input logic bump, input logic trim);
        logic [10:0] r;
        r = bump ? c + 11'd32 : c;
        if (trim) r = {r[10:5], 5'd0};
        return r;
    endfunction

    function automatic exp_s model(input logic [7:0] b, input logic [10:0] x,
                                   input logic [10:0] y, input logic [1:0] sc,
                                   input logic [3:0] dep);
        exp_s e;
        int   f;
        f = 1 << sc;
        e.depth = dep;
        e.draw = 0; e.leave = 0; e.pop = 0; e.bad = 0;
        if (b[7]) begin
            e.x = b[5] ? x - 11'(int'(b[4:3]) * f) : x + 11'(int'(b[4:3]) * f);
            e.y = b[2] ? y - 11'(int'(b[1:0]) * f) : y + 11'(int'(b[1:0]) * f);
            e.draw = b[6];
        end else begin
            e.x = ctl_axis(x, b[4], b[3]);
            e.y = ctl_axis(y, b[1], b[0]);
            e.leave = b[6];
            if (b[5]) begin
                if (dep == 0) e.bad = 1;
                else begin e.pop = 1; e.depth = dep - 1; end
            end
        end
        return e;
    endfunction

    task automatic cmp_step(input string req, input exp_s e, input logic [10:0] ox,
                            input logic [10:0] oy, input logic last);
        chk({req, " step"}, int'(step_o), 1);
        chk({req, " done"}, int'(done_o), int'(last));
        chk({req, " x"}, int'(x_o), int'(e.x));
        chk({req, " y"}, int'(y_o), int'(e.y));
        chk({req, " R3 draw"}, int'(draw_o), int'(e.draw));
        if (e.draw) begin
            chk("R3 x0", int'(draw_x0_o), int'(ox));
            chk("R3 y0", int'(draw_y0_o), int'(oy));
            chk("R3 x1", int'(draw_x1_o), int'(e.x));
            chk("R3 y1", int'(draw_y1_o), int'(e.y));
        end
        chk({req, " R7 exit"}, int'(exit_o), int'(e.leave));
        chk({req, " R5 pop"}, int'(pop_o), int'(e.pop));
        chk({req, " R6 illegal"}, int'(illegal_o), int'(e.bad));
    endtask

    task automatic run_word(input string req, input logic ent, input logic [15:0] w,
                            input logic [10:0] x, input logic [10:0] y,
                            input logic [1:0] sc, input logic [3:0] dep);
        exp_s e1, e2;
        logic last1;
        @(negedge clk);
        start_i = 1; entry_i = ent; word_i = w; x_i = x; y_i = y;
        scale_i = sc; depth_i = dep;
        e1 = model(ent ? w[7:0] : w[15:8], x, y, sc, dep);
        last1 = ent || e1.leave || e1.bad;
        @(negedge clk);
        start_i = 0; word_i = 16'h0000; x_i = 11'h7FF; y_i = 11'h7FF; scale_i = 2'd3;
        cmp_step({req, " R8 first"}, e1, x, y, last1);
        chk({req, " R8 busy"}, int'(busy_o), int'(!last1));
        if (!last1) begin
            e2 = model(w[7:0], e1.x, e1.y, sc, e1.depth);
            @(negedge clk);
            cmp_step({req, " R8 second"}, e2, e1.x, e1.y, 1'b1);
            chk({req, " R8 idle"}, int'(busy_o), 0);
        end
        @(negedge clk);
        chk({req, " R8 no extra step"}, int'(step_o), 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 step", int'(step_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 x", int'(x_o), 0);
        chk("R1 y", int'(y_o), 0);
        chk("R1 flags", int'({draw_o, exit_o, pop_o, illegal_o}), 0);
    endtask

    task automatic t_increments();
        for (int s = 0; s < 4; s++) begin
            run_word("R2 scale", 1'b0, 16'hDA_93, 11'd500, 11'd700, 2'(s), 4'd2);
            run_word("R2 neg", 1'b0, 16'hBE_8F, 11'd300, 11'd900, 2'(s), 4'd2);
        end
    endtask

    task automatic t_wrap();
        run_word("R2 wrap up", 1'b0, 16'hDB_80, 11'd2040, 11'd2045, 2'd3, 4'd0);
        run_word("R2 wrap down", 1'b0, 16'hBE_80, 11'd2, 11'd5, 2'd3, 4'd0);
    endtask

    task automatic t_control();
        run_word("R4 add then clear", 1'b0, 16'h1B_00, 11'h3F5, 11'h7EA, 2'd0, 4'd0);
        run_word("R4 single", 1'b0, 16'h10_09, 11'h123, 11'h456, 2'd1, 4'd0);
        run_word("R4 mixed", 1'b0, 16'h02_D5, 11'h7F0, 11'h011, 2'd2, 4'd0);
    endtask

    task automatic t_returns();
        run_word("R5 pop then R6 illegal", 1'b0, 16'h20_20, 11'd10, 11'd20, 2'd0, 4'd1);
        run_word("R5 double pop", 1'b0, 16'h20_20, 11'd10, 11'd20, 2'd0, 4'd5);
        run_word("R6 empty high", 1'b0, 16'h20_81, 11'd10, 11'd20, 2'd0, 4'd0);
    endtask

    task automatic t_exit();
        run_word("R7 high exit", 1'b0, 16'h5B_C9, 11'd77, 11'd88, 2'd1, 4'd0);
        run_word("R7 low exit", 1'b0, 16'hC9_40, 11'd77, 11'd88, 2'd1, 4'd0);
    endtask

    task automatic t_entry();
        run_word("R9 entry", 1'b1, 16'h20_C9, 11'd400, 11'd400, 2'd2, 4'd0);
        run_word("R9 entry ctl", 1'b1, 16'hFF_12, 11'd400, 11'd400, 2'd2, 4'd0);
    endtask

    task automatic t_busy_ignore();
        exp_s e1, e2;
        @(negedge clk);
        start_i = 1; entry_i = 0; word_i = 16'hC8_C1; x_i = 11'd100; y_i = 11'd100;
        scale_i = 2'd1; depth_i = 4'd0;
        e1 = model(8'hC8, 11'd100, 11'd100, 2'd1, 4'd0);
        e2 = model(8'hC1, e1.x, e1.y, 2'd1, 4'd0);
        @(negedge clk);
        word_i = 16'h1B_1B; entry_i = 1; x_i = 11'd0; y_i = 11'd0; scale_i = 2'd3;
        chk("R10 busy", int'(busy_o), 1);
        @(negedge clk);
        start_i = 0;
        cmp_step("R10 low unaffected", e2, e1.x, e1.y, 1'b1);
        @(negedge clk);
        chk("R10 no restart", int'(step_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_increments();
        t_wrap();
        t_control();
        t_returns();
        t_exit();
        t_entry();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule